// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block steers the two ALU operands of a five-stage in-order pipeline toward the freshest copy of each source register. For the instruction sitting in the execute stage, it compares that instruction's two source register numbers against the destination numbers of the two older instructions still in flight. The first older instruction holds its result in the execute/memory register. The second holds its result in the memory/writeback register. Each operand then takes one of three values: the register-file read, the older ALU result, or the writeback data.

The block also contains the small decode-side selector that fills the destination and second-source fields written into the execute stage register. It turns a non-writing instruction into a zero destination, so zero means "no write" everywhere downstream. It also clears the second-source field when the rt field names the destination rather than an operand. Stall generation, branches, the register file and the ALU are outside the block.

Top module: `forward_unit`

## Requirements
- R1: Each operand select is a 2-bit code: 2'b00 selects the register-file value from the execute stage, 2'b10 selects the ALU result held one stage ahead, and 2'b01 selects the writeback data held two stages ahead. The code 2'b11 never appears.
- R2: When both older stages match a source, the stage one ahead (code 2'b10) wins. The writeback stage (code 2'b01) is chosen only when the stage one ahead does not match.
- R3: A match requires a destination number that is non-zero and equal to the source number. A destination of zero never produces 2'b10 or 2'b01.
- R4: When `decRegWrite` is 0, `decDestNum` is 0, whatever the register fields are.
- R5: When `decRegWrite` is 1, `decDestNum` equals `decRtField` if `decRegDst` is 1, and equals `decRdField` if `decRegDst` is 0.
- R6: When `decRegDst` is 1, `decSrcBNum` is 0. When `decRegDst` is 0, `decSrcBNum` equals `decRtField`. This holds for either value of `decRegWrite`.
- R7: `operandA` and `operandB` each carry the data value named by their own select code.
- R8: Operand A is decided from `exSrcA` and operand B from `exSrcB` by identical, independent logic. A match on one source has no effect on the other operand's select or value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decRegWrite | input | 1 | Decoded instruction writes a register |
| decRegDst | input | 1 | 1: destination is the rt field; 0: destination is the rd field |
| decRtField | input | REG_W | rt field of the decoded instruction |
| decRdField | input | REG_W | rd field of the decoded instruction |
| decDestNum | output | REG_W | Destination number passed into the execute stage |
| decSrcBNum | output | REG_W | Second-source number passed into the execute stage |
| exSrcA | input | REG_W | First source number in the execute stage |
| exSrcB | input | REG_W | Second source number in the execute stage |
| memDest | input | REG_W | Destination number one stage ahead (0 = no write) |
| wbDest | input | REG_W | Destination number two stages ahead (0 = no write) |
| exRegA | input | DATA_W | Register-file value for operand A |
| exRegB | input | DATA_W | Register-file value for operand B |
| memAluResult | input | DATA_W | ALU result held one stage ahead |
| wbWriteData | input | DATA_W | Writeback data held two stages ahead |
| selA | output | 2 | Operand A select code |
| selB | output | 2 | Operand B select code |
| operandA | output | DATA_W | Selected operand A |
| operandB | output | DATA_W | Selected operand B |

## Verification
The bench sweeps every combination of the two source numbers and the two older destinations over the set {0, 1, 2, 31}. This covers several cases:
- both stages naming the same register, which separates correct priority from reversed priority;
- zero destinations equal to zero sources, which catch a missing non-zero test;
- operand A matching while B does not, which exposes crossed or shared logic.

Each operand input carries a distinct data word, so a wrong mux leg shows up as a wrong value. The decode selector is swept over both control bits and several field values, with rt different from rd, so a swapped field choice or a missing zeroing is visible.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WRITEBK = 2'b01,
    SEL_ALUPREV = 2'b10
  } fwdSel_t;

  typedef struct packed {
    fwdSel_t selA;
    fwdSel_t selB;
  } fwdStrobes_t;

  localparam int NUM_OPERANDS = 2;
endpackage

// File: rtl/fwd_dest_select.sv
module fwd_dest_select #(
  parameter int REG_W = 5
) (
  input  logic             regWrite,
  input  logic             regDstRt,
  input  logic [REG_W-1:0] rtField,
  input  logic [REG_W-1:0] rdField,
  output logic [REG_W-1:0] destNum,
  output logic [REG_W-1:0] srcBNum
);
  localparam logic [REG_W-1:0] NO_REG = '0;

  always_comb begin
    if (!regWrite)     destNum = NO_REG;
    else if (regDstRt) destNum = rtField;
    else               destNum = rdField;
  end

  always_comb begin
    srcBNum = regDstRt ? NO_REG : rtField;
  end
endmodule

// File: rtl/fwd_control.sv
module fwd_control
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic [REG_W-1:0] memDest,
  input  logic [REG_W-1:0] wbDest,
  output fwdStrobes_t      strobes
);
  localparam logic [REG_W-1:0] NO_REG = '0;

  logic [REG_W-1:0] srcNum [NUM_OPERANDS];
  fwdSel_t          selArr [NUM_OPERANDS];

  assign srcNum[0] = srcA;
  assign srcNum[1] = srcB;

  for (genvar op = 0; op < NUM_OPERANDS; op++) begin : g_op
    logic hitMem;
    logic hitWb;
    assign hitMem = (memDest != NO_REG) && (memDest == srcNum[op]);
    assign hitWb  = (wbDest  != NO_REG) && (wbDest  == srcNum[op]);
    always_comb begin
      if (hitMem)     selArr[op] = SEL_ALUPREV;
      else if (hitWb) selArr[op] = SEL_WRITEBK;
      else            selArr[op] = SEL_REGFILE;
    end
  end

  assign strobes.selA = selArr[0];
  assign strobes.selB = selArr[1];
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t       strobes,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] aluPrev,
  input  logic [DATA_W-1:0] wbData,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);
  logic [DATA_W-1:0] regVal [NUM_OPERANDS];
  logic [DATA_W-1:0] opVal  [NUM_OPERANDS];
  fwdSel_t           sel    [NUM_OPERANDS];

  assign regVal[0] = regA;
  assign regVal[1] = regB;
  assign sel[0]    = strobes.selA;
  assign sel[1]    = strobes.selB;

  for (genvar op = 0; op < NUM_OPERANDS; op++) begin : g_mux
    always_comb begin
      unique case (sel[op])
        SEL_ALUPREV: opVal[op] = aluPrev;
        SEL_WRITEBK: opVal[op] = wbData;
        default:     opVal[op] = regVal[op];
      endcase
    end
  end

  assign opA = opVal[0];
  assign opB = opVal[1];
endmodule

// File: rtl/forward_unit.sv
module forward_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              decRegWrite,
  input  logic              decRegDst,
  input  logic [REG_W-1:0]  decRtField,
  input  logic [REG_W-1:0]  decRdField,
  output logic [REG_W-1:0]  decDestNum,
  output logic [REG_W-1:0]  decSrcBNum,
  input  logic [REG_W-1:0]  exSrcA,
  input  logic [REG_W-1:0]  exSrcB,
  input  logic [REG_W-1:0]  memDest,
  input  logic [REG_W-1:0]  wbDest,
  input  logic [DATA_W-1:0] exRegA,
  input  logic [DATA_W-1:0] exRegB,
  input  logic [DATA_W-1:0] memAluResult,
  input  logic [DATA_W-1:0] wbWriteData,
  output logic [1:0]        selA,
  output logic [1:0]        selB,
  output logic [DATA_W-1:0] operandA,
  output logic [DATA_W-1:0] operandB
);
  fwdStrobes_t strobes;

  fwd_dest_select #(.REG_W(REG_W)) i_destSel (
    .regWrite (decRegWrite),
    .regDstRt (decRegDst),
    .rtField  (decRtField),
    .rdField  (decRdField),
    .destNum  (decDestNum),
    .srcBNum  (decSrcBNum)
  );

  fwd_control #(.REG_W(REG_W)) i_ctrl (
    .srcA    (exSrcA),
    .srcB    (exSrcB),
    .memDest (memDest),
    .wbDest  (wbDest),
    .strobes (strobes)
  );

  fwd_datapath #(.DATA_W(DATA_W)) i_dp (
    .strobes (strobes),
    .regA    (exRegA),
    .regB    (exRegB),
    .aluPrev (memAluResult),
    .wbData  (wbWriteData),
    .opA     (operandA),
    .opB     (operandB)
  );

  assign selA = strobes.selA;
  assign selB = strobes.selB;
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic              decRegWrite,
  input logic              decRegDst,
  input logic [REG_W-1:0]  decRtField,
  input logic [REG_W-1:0]  decDestNum,
  input logic [REG_W-1:0]  decSrcBNum,
  input logic [REG_W-1:0]  exSrcA,
  input logic [REG_W-1:0]  exSrcB,
  input logic [REG_W-1:0]  memDest,
  input logic [REG_W-1:0]  wbDest,
  input logic [DATA_W-1:0] exRegA,
  input logic [DATA_W-1:0] exRegB,
  input logic [DATA_W-1:0] memAluResult,
  input logic [DATA_W-1:0] wbWriteData,
  input logic [1:0]        selA,
  input logic [1:0]        selB,
  input logic [DATA_W-1:0] operandA,
  input logic [DATA_W-1:0] operandB
);
  always_comb begin
    assert_legal_code_R1: assert (selA != 2'b11 && selB != 2'b11);
    assert_alu_fwd_a_R3: assert (selA != 2'b10 || (memDest != '0 && memDest == exSrcA));
    assert_alu_fwd_b_R8: assert (selB != 2'b10 || (memDest != '0 && memDest == exSrcB));
    assert_wb_priority_R2: assert (selA != 2'b01 ||
      (wbDest != '0 && wbDest == exSrcA && !(memDest != '0 && memDest == exSrcA)));
    assert_nowrite_zero_R4: assert (decRegWrite || decDestNum == '0);
    assert_srcb_field_R6: assert (decRegDst ? (decSrcBNum == '0) : (decSrcBNum == decRtField));
    assert_mux_a_R7: assert (operandA == (selA == 2'b10 ? memAluResult :
                                          selA == 2'b01 ? wbWriteData : exRegA));
    assert_mux_b_R7: assert (operandB == (selB == 2'b10 ? memAluResult :
                                          selB == 2'b01 ? wbWriteData : exRegB));
  end
endmodule

bind forward_unit fwd_checker #(.REG_W(REG_W), .DATA_W(DATA_W)) i_fwdChk (
  .decRegWrite  (decRegWrite),
  .decRegDst    (decRegDst),
  .decRtField   (decRtField),
  .decDestNum   (decDestNum),
  .decSrcBNum   (decSrcBNum),
  .exSrcA       (exSrcA),
  .exSrcB       (exSrcB),
  .memDest      (memDest),
  .wbDest       (wbDest),
  .exRegA       (exRegA),
  .exRegB       (exRegB),
  .memAluResult (memAluResult),
  .wbWriteData  (wbWriteData),
  .selA         (selA),
  .selB         (selB),
  .operandA     (operandA),
  .operandB     (operandB)
);

// File: tb/test_forward_unit.sv
module test_forward_unit;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              decRegWrite, decRegDst;
  logic [REG_W-1:0]  decRtField, decRdField, decDestNum, decSrcBNum;
  logic [REG_W-1:0]  exSrcA, exSrcB, memDest, wbDest;
  logic [DATA_W-1:0] exRegA, exRegB, memAluResult, wbWriteData;
  logic [1:0]        selA, selB;
  logic [DATA_W-1:0] operandA, operandB;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  forward_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) i_forward_unit (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] refSel(logic [REG_W-1:0] src, logic [REG_W-1:0] md,
                                        logic [REG_W-1:0] wd);
    if (md != 0 && md == src) return 2'b10;
    if (wd != 0 && wd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] refVal(logic [1:0] s, logic [DATA_W-1:0] r);
    return (s == 2'b10) ? memAluResult : (s == 2'b01) ? wbWriteData : r;
  endfunction

  initial begin
    logic [REG_W-1:0] vals [4];
    vals[0] = 5'd0; vals[1] = 5'd1; vals[2] = 5'd2; vals[3] = 5'd31;
    exRegA = 32'hAAAA_0001; exRegB = 32'hBBBB_0002;
    memAluResult = 32'hCCCC_0003; wbWriteData = 32'hDDDD_0004;
    decRegWrite = 0; decRegDst = 0; decRtField = 0; decRdField = 0;
    exSrcA = 0; exSrcB = 0; memDest = 0; wbDest = 0;
    @(negedge clk);
    // idle state: all-zero fields forward nothing (R3)
    check("R3 idle selA", {30'd0, selA}, 32'd0);
    check("R3 idle selB", {30'd0, selB}, 32'd0);
    check("R4 idle dest", {27'd0, decDestNum}, 32'd0);

    // operand sweep: R1 R2 R3 R7 R8
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int m = 0; m < 4; m++)
          for (int w = 0; w < 4; w++) begin
            exSrcA = vals[a]; exSrcB = vals[b]; memDest = vals[m]; wbDest = vals[w];
            @(negedge clk);
            begin
              logic [1:0] ea, eb;
              ea = refSel(exSrcA, memDest, wbDest);
              eb = refSel(exSrcB, memDest, wbDest);
              check("R2 selA", {30'd0, selA}, {30'd0, ea});
              check("R8 selB", {30'd0, selB}, {30'd0, eb});
              check("R7 operandA", operandA, refVal(ea, exRegA));
              check("R7 operandB", operandB, refVal(eb, exRegB));
              check("R1 no code 11", {31'd0, (selA == 2'b11 || selB == 2'b11)}, 32'd0);
            end
          end

    // decode selector sweep: R4 R5 R6
    for (int wr = 0; wr < 2; wr++)
      for (int ds = 0; ds < 2; ds++)
        for (int t = 0; t < 4; t++) begin
          decRegWrite = wr[0]; decRegDst = ds[0];
          decRtField = vals[t] ^ 5'd9; decRdField = vals[3 - t] ^ 5'd20;
          @(negedge clk);
          if (wr == 0) check("R4 dest", {27'd0, decDestNum}, 32'd0);
          else check("R5 dest", {27'd0, decDestNum},
                     {27'd0, (ds == 1) ? decRtField : decRdField});
          check("R6 srcB", {27'd0, decSrcBNum}, {27'd0, (ds == 1) ? 5'd0 : decRtField});
        end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule